// File: doc/BRIEF.md
# Reprogrammable Probe Trigger Unit

This block watches a group of probe signals, each with its own width set at build time, and produces a single trigger for a capture controller. Every probe has one comparator. Its operation and its constant argument sit in registers that are written at run time, so the trigger condition can be changed without rebuilding the design. The comparator can react to the probe's value history: an increase, a decrease or any change since the previous clock. It can also compare the probe with the programmed constant.

The per-probe hits are merged into one trigger by a wide OR, which is the default, or by a wide AND. Only probes with a live operation take part in the merge. The trigger is registered. It reports the probe values sampled at the previous rising edge of the clock.

Top module: `ptrig_top`

## Requirements
- R1: While `rst` is high and on the first edge after it, `trig` is 0. Reset sets every operation to 0 (off), every argument to 0 and the merge mode to OR.
- R2: An operation is written with `cfg_field`=0 and `cfg_slot`=probe index, using code `cfg_wdata[3:0]`. The codes are 0 off, 1 rise, 2 fall, 3 change, 4 greater, 5 less, 6 greater-or-equal, 7 less-or-equal, 8 equal and 9 not-equal.
- R3: Rise (1) hits when the unsigned probe value is larger than its value one edge earlier. Fall (2) hits when it is smaller. This is a magnitude test, not a test on single bits.
- R4: Change (3) hits when the probe value differs from its value one edge earlier.
- R5: Codes 4 to 7 compare the probe with its argument as unsigned numbers (probe > arg, probe < arg, probe >= arg, probe <= arg).
- R6: Code 8 hits on probe == arg and code 9 hits on probe != arg.
- R7: An argument is written with `cfg_field`=1. It keeps only the low bits of `cfg_wdata` that match the width of its probe, and the upper bits are ignored.
- R8: In OR mode (`cfg_slot`=NPROBE, `cfg_field`=0, `cfg_wdata[0]`=0), `trig` rises when any enabled probe hits.
- R9: In AND mode (`cfg_wdata[0]`=1 at the same address), `trig` requires every enabled probe to hit. A probe set to off does not block the result.
- R10: When no probe is enabled, `trig` stays 0 in both modes.
- R11: The first edge after reset has no valid history. Codes 1 to 3 cannot hit there, even when the probe differs from the cleared history value.
- R12: `trig` shows the result for the inputs at the previous edge. A configuration write takes effect from the following edge, and the edge that performs the write still uses the old setting. A write made while `rst` is high is kept.
- R13: Codes 10 to 15 act as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| probes | input | TOTAL_W (13) | Probe bus with probe 0 in the lowest bits; default widths 1, 3, 9 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | AW (2) | Probe index, or NPROBE for the merge-mode register |
| cfg_field | input | 1 | 0 selects the operation, 1 selects the argument |
| cfg_wdata | input | DW (9) | Write data |
| trig | output | 1 | Registered combined trigger |

## Verification
Two events can fall on the same edge: a configuration write, and a trigger evaluation that uses the setting being replaced. The bench provokes this by changing a probe's operation, or the merge mode, in the same cycle that the probe moves in a way the old and new settings judge differently. A behavioural model keeps the old setting for that edge and the new one afterwards, and `trig` is compared with the model on every clock. A reset write of a history operation is likewise combined with a probe value that would look like a rise against the cleared history. This checks that the first edge stays quiet.

// File: rtl/ptrig_pkg.sv
`timescale 1ns/1ps
package ptrig_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_OFF  = 4'd0,
    OP_RISE = 4'd1,
    OP_FALL = 4'd2,
    OP_CHG  = 4'd3,
    OP_GT   = 4'd4,
    OP_LT   = 4'd5,
    OP_GE   = 4'd6,
    OP_LE   = 4'd7,
    OP_EQ   = 4'd8,
    OP_NE   = 4'd9
  } trig_op_e;

  // a code is live when it names one of the nine operations
  function automatic logic op_live(logic [OP_W-1:0] code);
    return (code >= 4'd1) && (code <= 4'd9);
  endfunction

  // operations that look at the previous sample
  function automatic logic op_history(logic [OP_W-1:0] code);
    return (code >= 4'd1) && (code <= 4'd3);
  endfunction
endpackage

// File: rtl/ptrig_slot.sv
`timescale 1ns/1ps
module ptrig_slot
  import ptrig_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  probe,
  input  logic          we_op,
  input  logic          we_arg,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic          active
);
  logic [OP_W-1:0] op_q;
  logic [W-1:0]    arg_q;
  logic [W-1:0]    prev_q;
  logic            hist_ok_q;

  logic            unused_wdata;
  assign unused_wdata = ^wdata;

  // configuration: a write wins over reset so setup can happen in reset
  always_ff @(posedge clk) begin
    if (we_op)    op_q <= wdata[OP_W-1:0];
    else if (rst) op_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (we_arg)   arg_q <= wdata[W-1:0];
    else if (rst) arg_q <= '0;
  end

  // history of the probe
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      hist_ok_q <= 1'b0;
    end else begin
      prev_q    <= probe;
      hist_ok_q <= 1'b1;
    end
  end

  // named events
  logic ev_up, ev_down, ev_moved;
  logic ev_gt, ev_lt, ev_eq;
  assign ev_up    = hist_ok_q && (probe > prev_q);
  assign ev_down  = hist_ok_q && (probe < prev_q);
  assign ev_moved = hist_ok_q && (probe != prev_q);
  assign ev_gt    = probe > arg_q;
  assign ev_lt    = probe < arg_q;
  assign ev_eq    = probe == arg_q;

  always_comb begin
    case (trig_op_e'(op_q))
      OP_RISE: hit = ev_up;
      OP_FALL: hit = ev_down;
      OP_CHG:  hit = ev_moved;
      OP_GT:   hit = ev_gt;
      OP_LT:   hit = ev_lt;
      OP_GE:   hit = !ev_lt;
      OP_LE:   hit = !ev_gt;
      OP_EQ:   hit = ev_eq;
      OP_NE:   hit = !ev_eq;
      default: hit = 1'b0;
    endcase
  end

  assign active = op_live(op_q);

  p_first_sample_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!hist_ok_q && op_history(op_q)) |-> !hit);
  p_rise_is_larger_r3: assert property (@(posedge clk) disable iff (rst)
    (op_q == 4'd1 && hit) |-> (probe > prev_q));
  p_fall_is_smaller_r3: assert property (@(posedge clk) disable iff (rst)
    (op_q == 4'd2 && hit) |-> (probe < prev_q));
  p_change_differs_r4: assert property (@(posedge clk) disable iff (rst)
    (op_q == 4'd3 && hit) |-> (probe != prev_q));
  p_reserved_idle_r13: assert property (@(posedge clk) disable iff (rst)
    (op_q > 4'd9) |-> (!active && !hit));
  p_history_tracks_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prev_q == $past(probe)));
endmodule

// File: rtl/ptrig_reduce.sv
`timescale 1ns/1ps
module ptrig_reduce #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hits,
  input  logic [N-1:0] act,
  input  logic         and_mode,
  output logic         trig
);
  logic any_act, or_v, and_v, trig_d;

  assign any_act = |act;
  assign or_v    = |(hits & act);
  assign and_v   = &(hits | ~act);
  assign trig_d  = any_act && (and_mode ? and_v : or_v);

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= trig_d;
  end

  p_none_enabled_low_r10: assert property (@(posedge clk) disable iff (rst)
    (act == '0) |=> !trig);
  p_or_needs_hit_r8: assert property (@(posedge clk) disable iff (rst)
    (!and_mode && ((hits & act) == '0)) |=> !trig);
  p_and_all_fire_r9: assert property (@(posedge clk) disable iff (rst)
    (and_mode && (act != '0) && ((hits & act) == act)) |=> trig);
  p_and_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    (and_mode && ((~hits & act) != '0)) |=> !trig);
endmodule

// File: rtl/ptrig_top.sv
`timescale 1ns/1ps
module ptrig_top
  import ptrig_pkg::*;
#(
  parameter int NPROBE = 3,
  parameter int PW [NPROBE] = '{1, 3, 9},
  localparam int TOTAL_W = sum_w(NPROBE),
  localparam int MAXW    = max_w(),
  localparam int DW      = (MAXW > OP_W) ? MAXW : OP_W,
  localparam int AW      = $clog2(NPROBE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TOTAL_W-1:0] probes,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_slot,
  input  logic               cfg_field,
  input  logic [DW-1:0]      cfg_wdata,
  output logic               trig
);
  function automatic int sum_w(int upto);
    int s = 0;
    for (int k = 0; k < upto; k++) s += PW[k];
    return s;
  endfunction

  function automatic int max_w();
    int m = 1;
    for (int k = 0; k < NPROBE; k++) if (PW[k] > m) m = PW[k];
    return m;
  endfunction

  logic [NPROBE-1:0] hit_v, act_v;
  logic              and_q;
  logic              mode_we;

  assign mode_we = cfg_we && (cfg_slot == AW'(NPROBE)) && !cfg_field;

  always_ff @(posedge clk) begin
    if (mode_we)  and_q <= cfg_wdata[0];
    else if (rst) and_q <= 1'b0;
  end

  for (genvar g = 0; g < NPROBE; g++) begin : g_slot
    localparam int WG  = PW[g];
    localparam int OFF = sum_w(g);
    logic sel;
    assign sel = cfg_we && (cfg_slot == AW'(g));

    ptrig_slot #(.W(WG), .DW(DW)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .probe  (probes[OFF +: WG]),
      .we_op  (sel && !cfg_field),
      .we_arg (sel && cfg_field),
      .wdata  (cfg_wdata),
      .hit    (hit_v[g]),
      .active (act_v[g])
    );
  end

  ptrig_reduce #(.N(NPROBE)) u_reduce (
    .clk      (clk),
    .rst      (rst),
    .hits     (hit_v),
    .act      (act_v),
    .and_mode (and_q),
    .trig     (trig)
  );

  p_mode_write_r12: assert property (@(posedge clk)
    mode_we |=> (and_q == $past(cfg_wdata[0])));
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !trig);
endmodule

// File: tb/sim_ptrig_top.sv
`timescale 1ns/1ps
module sim_ptrig_top;
  localparam int N = 3;
  localparam int TW = 13;
  localparam int PWB [N] = '{1, 3, 9};
  localparam int OFB [N] = '{0, 1, 4};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] probes = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_slot = '0;
  logic          cfg_field = 1'b0;
  logic [8:0]    cfg_wdata = '0;
  logic          trig;

  always #2.5 clk = ~clk;

  ptrig_top u0 (
    .clk(clk), .rst(rst), .probes(probes), .cfg_we(cfg_we),
    .cfg_slot(cfg_slot), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .trig(trig)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // behavioural reference
  int m_op [N];
  int m_arg [N];
  int m_prev [N];
  bit m_valid;
  bit m_and;
  bit exp_trig;

  function automatic int get_p(int i);
    return int'((probes >> OFB[i])) & ((1 << PWB[i]) - 1);
  endfunction

  function automatic bit judge(int i, int cur);
    case (m_op[i])
      1: return m_valid && (cur > m_prev[i]);
      2: return m_valid && (cur < m_prev[i]);
      3: return m_valid && (cur != m_prev[i]);
      4: return cur > m_arg[i];
      5: return cur < m_arg[i];
      6: return cur >= m_arg[i];
      7: return cur <= m_arg[i];
      8: return cur == m_arg[i];
      9: return cur != m_arg[i];
      default: return 0;
    endcase
  endfunction

  task automatic apply_write();
    if (!cfg_we) return;
    if (int'(cfg_slot) < N) begin
      if (!cfg_field) m_op[cfg_slot] = int'(cfg_wdata) & 15;
      else            m_arg[cfg_slot] = int'(cfg_wdata) & ((1 << PWB[cfg_slot]) - 1);
    end else if (int'(cfg_slot) == N && !cfg_field) begin
      m_and = cfg_wdata[0];
    end
  endtask

  task automatic check(bit ok, string req, bit act, bit expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s at %0t: trig=%0b expected %0b", req, $time, act, expv);
    end
  endtask

  task automatic cyc(string req);
    int cur [N];
    bit any, orv, andv;
    @(posedge clk);
    for (int i = 0; i < N; i++) cur[i] = get_p(i);
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_op[i] = 0; m_arg[i] = 0; m_prev[i] = 0;
      end
      m_and = 0; m_valid = 0; exp_trig = 0;
      apply_write();
    end else begin
      any = 0; orv = 0; andv = 1;
      for (int i = 0; i < N; i++) begin
        if (m_op[i] >= 1 && m_op[i] <= 9) begin
          any = 1;
          if (judge(i, cur[i])) orv = 1; else andv = 0;
        end
      end
      exp_trig = any && (m_and ? andv : orv);
      for (int i = 0; i < N; i++) m_prev[i] = cur[i];
      m_valid = 1;
      apply_write();
    end
    @(negedge clk);
    check(trig === exp_trig, req, trig, exp_trig);
  endtask

  task automatic wr(int slot, bit field, int data, string req);
    cfg_we = 1; cfg_slot = 2'(slot); cfg_field = field; cfg_wdata = 9'(data);
    cyc(req);
    cfg_we = 0;
  endtask

  task automatic set_p(int i, int v);
    logic [TW-1:0] m;
    m = TW'(((1 << PWB[i]) - 1)) << OFB[i];
    probes = (probes & ~m) | ((TW'(v) << OFB[i]) & m);
  endtask

  task automatic all_off(string req);
    for (int i = 0; i < N; i++) wr(i, 0, 0, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++; n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    // R1 reset state
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin probes = TW'(k * 977); cyc("R1"); end
    rst = 0;
    for (int k = 0; k < 6; k++) begin probes = TW'(k * 3331 + 5); cyc("R1"); end
    // R10 all disabled, both modes
    wr(3, 0, 1, "R10");
    for (int k = 0; k < 6; k++) begin probes = TW'(k * 1237 + 9); cyc("R10"); end
    wr(3, 0, 0, "R10");
    // R13 reserved codes
    for (int c = 10; c < 16; c++) begin
      wr(2, 0, c, "R13");
      for (int k = 0; k < 3; k++) begin set_p(2, k * 171); cyc("R13"); end
    end
    all_off("R2");
    // R3 rise on 1-bit probe and fall on 3-bit probe
    wr(0, 0, 1, "R2");
    wr(1, 0, 2, "R2");
    for (int k = 0; k < 12; k++) begin
      set_p(0, (k / 2) % 2); set_p(1, (k * 5) % 8); cyc("R3");
    end
    all_off("R3");
    // R3 magnitude, not bit edges: 0x100 -> 0x0FF -> 0x100
    wr(2, 0, 1, "R3");
    set_p(2, 9'h100); cyc("R3");
    set_p(2, 9'h0FF); cyc("R3");
    set_p(2, 9'h100); cyc("R3");
    set_p(2, 9'h100); cyc("R3");
    wr(2, 0, 2, "R3");
    set_p(2, 9'h0FF); cyc("R3");
    set_p(2, 9'h101); cyc("R3");
    // R4 change
    all_off("R4");
    wr(1, 0, 3, "R4");
    for (int k = 0; k < 10; k++) begin set_p(1, (k / 3) * 3); cyc("R4"); end
    all_off("R5");
    // R5 unsigned ordering against argument 0x80
    wr(2, 1, 9'h080, "R5");
    for (int c = 4; c <= 7; c++) begin
      wr(2, 0, c, "R5");
      set_p(2, 9'h07F); cyc("R5");
      set_p(2, 9'h080); cyc("R5");
      set_p(2, 9'h081); cyc("R5");
      set_p(2, 9'h1FF); cyc("R5");
      set_p(2, 9'h000); cyc("R5");
    end
    // R6 equal / not equal
    wr(2, 1, 9'h1A5, "R6");
    for (int c = 8; c <= 9; c++) begin
      wr(2, 0, c, "R6");
      set_p(2, 9'h1A5); cyc("R6");
      set_p(2, 9'h1A4); cyc("R6");
      set_p(2, 9'h1A5); cyc("R6");
    end
    all_off("R7");
    // R7 argument width truncation: 0x1F5 into a 3-bit argument gives 5
    wr(1, 1, 9'h1F5, "R7");
    wr(1, 0, 8, "R7");
    for (int v = 0; v < 8; v++) begin set_p(1, v); cyc("R7"); end
    // R8 OR mode: probe1 EQ 5, probe2 GT 0x80
    wr(2, 1, 9'h080, "R8");
    wr(2, 0, 4, "R8");
    for (int k = 0; k < 12; k++) begin
      set_p(1, (k * 3) % 8); set_p(2, (k * 53) % 512); cyc("R8");
    end
    // R9 AND mode, probe0 off must not block
    wr(3, 0, 1, "R9");
    for (int k = 0; k < 12; k++) begin
      set_p(0, k % 2); set_p(1, (k % 3 == 0) ? 5 : k % 8);
      set_p(2, (k % 2 == 0) ? 9'h1F0 : 9'h010); cyc("R9");
    end
    wr(0, 0, 1, "R9");
    for (int k = 0; k < 8; k++) begin
      set_p(0, k % 2); set_p(1, 5); set_p(2, 9'h1F0); cyc("R9");
    end
    // R12 write in the same cycle the probe moves; old setting used there
    all_off("R12");
    wr(3, 0, 0, "R12");
    wr(1, 0, 8, "R12");
    set_p(1, 5); cyc("R12");
    set_p(1, 4); wr(1, 0, 2, "R12");
    set_p(1, 2); cyc("R12");
    set_p(1, 6); wr(1, 0, 0, "R12");
    set_p(1, 1); cyc("R12");
    wr(1, 0, 9, "R12");
    set_p(1, 3); wr(3, 0, 1, "R12");
    cyc("R12");
    // R11 history suppressed on first edge after reset, setup written in reset
    rst = 1;
    set_p(2, 0); cyc("R11");
    wr(2, 0, 1, "R11");
    wr(3, 0, 0, "R11");
    set_p(2, 7); cyc("R11");
    rst = 0;
    set_p(2, 9); cyc("R11");
    set_p(2, 12); cyc("R11");
    set_p(2, 12); cyc("R11");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule